// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel: a pixel clock enable, horizontal sync, vertical sync and data-enable. Every horizontal and vertical interval, and the active width and height, are programmed as the real count minus one. A line runs through four phases in a fixed order: sync, back porch, active, front porch. A frame steps through its lines in the same order. Data-enable is high only where the horizontal and vertical active phases overlap.

A divider with a bypass derives the pixel clock enable from the source clock. All raster counters advance only on that enable. Each of the three panel outputs has its own polarity bit. A frame interrupt has a trigger that picks one of the four vertical phases. It needs two enables, and its pending bit is cleared by writing a one. A live status bit shows when the raster is inside vertical sync. The configuration arrives on plain input ports. Register decode lies outside this block.

Top module: `lcd_tgen`

## Requirements
- R1: While reset is applied, `lcd_hsync`, `lcd_vsync` and `lcd_de` sit at their idle levels, which equal the matching `cfg_pol` bits. `vsync_stat` and `irq_pend` are 0. With `cfg_div_sel`=0, `pix_ce` is 1.
- R2: Each line is sync for `h_sync_m1`+1 pixel periods, then back porch for `h_back_m1`+1, then active for `h_act_m1`+1, then front porch for `h_front_m1`+1. `lcd_hsync` is active during the sync phase only.
- R3: Each frame is sync for `v_sync_m1`+1 lines, then back porch for `v_back_m1`+1 lines, then active for `v_act_m1`+1 lines, then front porch for `v_front_m1`+1 lines. `lcd_vsync` is active for whole lines during vertical sync. `lcd_de` is active only where the horizontal and vertical active phases overlap.
- R4: With `cfg_div_sel`=1, `pix_ce` is high in exactly one of every `cfg_div_m1`+1 source clocks. Every raster interval is stretched by that ratio.
- R5: With `cfg_div_sel`=0, `pix_ce` is high on every clock whatever the value of `cfg_div_m1`.
- R6: `cfg_pol` bit 0 inverts `lcd_hsync`, bit 1 inverts `lcd_vsync` and bit 2 inverts `lcd_de`. A bit set to 1 makes that output active-low.
- R7: `vsync_stat` is 1 exactly while the raster is in vertical sync. Polarity has no effect on it.
- R8: `irq_trig` picks the event that raises `irq_pend`: 0 = start of vertical sync, 1 = start of vertical back porch, 2 = start of vertical active, 3 = start of vertical front porch. `irq_pend` goes high one clock after the raster enters the chosen phase.
- R9: `irq_pend` is set only while `irq_glb_en` and `irq_frm_en` are both 1.
- R10: A one-clock pulse on `irq_clr` clears `irq_pend`. Without that pulse, `irq_pend` stays set.
- R11: Setting `cfg_run` starts a frame on the next `pix_ce`. The first active cycles of hsync and vsync coincide.
- R12: Clearing `cfg_run` lets the current frame run to its end, including all of its active lines. After that, the outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_run | input | 1 | Raster run request |
| cfg_div_sel | input | 1 | 1 = use divider, 0 = 1:1 bypass |
| cfg_div_m1 | input | DIV_W | Divide ratio minus one |
| h_sync_m1 | input | HW | Horizontal sync width minus one |
| h_back_m1 | input | HW | Horizontal back porch minus one |
| h_act_m1 | input | HW | Active columns minus one |
| h_front_m1 | input | HW | Horizontal front porch minus one |
| v_sync_m1 | input | VW | Vertical sync lines minus one |
| v_back_m1 | input | VW | Vertical back porch lines minus one |
| v_act_m1 | input | VW | Active lines minus one |
| v_front_m1 | input | VW | Vertical front porch lines minus one |
| cfg_pol | input | 3 | Inversion of hsync, vsync, de (bits 0, 1, 2) |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_frm_en | input | 1 | Frame interrupt enable |
| irq_trig | input | 2 | Frame interrupt trigger phase |
| irq_clr | input | 1 | Write-one-to-clear pulse for the pending bit |
| pix_ce | output | 1 | Pixel clock enable |
| lcd_hsync | output | 1 | Horizontal sync to the panel |
| lcd_vsync | output | 1 | Vertical sync to the panel |
| lcd_de | output | 1 | Data-enable to the panel |
| vsync_stat | output | 1 | Live vertical sync status |
| irq_pend | output | 1 | Frame interrupt pending / request |

## Verification
The panel outputs are decoded directly from registered counter state. They change in the clock right after the edge that moves a counter, and a frame starts one edge after `cfg_run` is seen with `pix_ce` high. The bench therefore locks onto the first cycle where `vsync_stat` is high and calls that cycle index zero. From then on it compares every falling-edge sample against the phase computed from that index divided by the clock ratio. The pending bit is registered once more than the raster state, so its expected first high sample is the phase start index plus one. The clear pulse takes effect at the edge that ends it.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } tg_phase_e;

   localparam int unsigned POL_HS = 0;
   localparam int unsigned POL_VS = 1;
   localparam int unsigned POL_DE = 2;
endpackage

// File: rtl/lcd_tgen_clkdiv.sv
module lcd_tgen_clkdiv #(
   parameter int unsigned DIV_W   = 8,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             div_sel,
   input  logic [DIV_W-1:0] div_m1,
   output logic             ce
);
   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] cnt;
         logic             at_end;

         assign at_end = (cnt >= div_m1);

         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               cnt <= '0;
            end else if (!div_sel || at_end) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end

         assign ce = !div_sel || at_end;
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = clk ^ rst ^ div_sel ^ (^div_m1);
         assign ce = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
   import lcd_tgen_pkg::*;
#(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hold,
   input  logic          step,
   input  logic [CW-1:0] sync_m1,
   input  logic [CW-1:0] back_m1,
   input  logic [CW-1:0] act_m1,
   input  logic [CW-1:0] front_m1,
   output tg_phase_e     phase,
   output logic          wrap
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] len_m1;
   logic          last;
   logic [1:0]    nxt_ph;

   always_comb begin
      unique case (phase)
         PH_SYNC:  len_m1 = sync_m1;
         PH_BACK:  len_m1 = back_m1;
         PH_ACT:   len_m1 = act_m1;
         default:  len_m1 = front_m1;
      endcase
   end

   // >= rather than == keeps the counter bounded if a field shrinks mid-phase
   assign last   = (cnt >= len_m1);
   assign nxt_ph = phase + 2'd1;
   assign wrap   = step && last && (phase == PH_FRONT);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (hold) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (step) begin
         if (last) begin
            cnt   <= '0;
            phase <= tg_phase_e'(nxt_ph);
         end else begin
            cnt   <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/lcd_tgen_irq.sv
module lcd_tgen_irq
   import lcd_tgen_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      running,
   input  tg_phase_e vphase,
   input  logic [1:0] trig,
   input  logic      glb_en,
   input  logic      frm_en,
   input  logic      clr,
   output logic      pend
);
   tg_phase_e ph_q;
   logic      run_q;
   logic      hit;
   tg_phase_e sel;

   assign sel = tg_phase_e'(trig);
   // first cycle in the selected phase (also covers the very first frame)
   assign hit = running && (vphase == sel) && !(run_q && (ph_q == sel));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ph_q  <= PH_SYNC;
         run_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         ph_q  <= vphase;
         run_q <= running;
         if (hit && glb_en && frm_en) begin
            pend <= 1'b1;
         end else if (clr) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
   import lcd_tgen_pkg::*;
#(
   parameter int unsigned HW      = 11,
   parameter int unsigned VW      = 11,
   parameter int unsigned DIV_W   = 8,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_run,
   input  logic             cfg_div_sel,
   input  logic [DIV_W-1:0] cfg_div_m1,
   input  logic [HW-1:0]    h_sync_m1,
   input  logic [HW-1:0]    h_back_m1,
   input  logic [HW-1:0]    h_act_m1,
   input  logic [HW-1:0]    h_front_m1,
   input  logic [VW-1:0]    v_sync_m1,
   input  logic [VW-1:0]    v_back_m1,
   input  logic [VW-1:0]    v_act_m1,
   input  logic [VW-1:0]    v_front_m1,
   input  logic [2:0]       cfg_pol,
   input  logic             irq_glb_en,
   input  logic             irq_frm_en,
   input  logic [1:0]       irq_trig,
   input  logic             irq_clr,
   output logic             pix_ce,
   output logic             lcd_hsync,
   output logic             lcd_vsync,
   output logic             lcd_de,
   output logic             vsync_stat,
   output logic             irq_pend
);
   generate
      if (HW < 2) begin : g_bad_hw
         $error("lcd_tgen: HW must be at least 2");
      end
      if (VW < 2) begin : g_bad_vw
         $error("lcd_tgen: VW must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("lcd_tgen: DIV_W must be 1..16");
      end
   endgenerate

   logic      running;
   logic      h_step;
   logic      h_wrap;
   logic      v_wrap;
   tg_phase_e h_ph;
   tg_phase_e v_ph;
   logic      hs_raw;
   logic      vs_raw;
   logic      de_raw;

   lcd_tgen_clkdiv #(.DIV_W(DIV_W), .HAS_DIV(HAS_DIV)) i_div (
      .clk    (clk),
      .rst    (rst),
      .div_sel(cfg_div_sel),
      .div_m1 (cfg_div_m1),
      .ce     (pix_ce)
   );

   assign h_step = running && pix_ce;

   lcd_tgen_axis #(.CW(HW)) i_hax (
      .clk     (clk),
      .rst     (rst),
      .hold    (!running),
      .step    (h_step),
      .sync_m1 (h_sync_m1),
      .back_m1 (h_back_m1),
      .act_m1  (h_act_m1),
      .front_m1(h_front_m1),
      .phase   (h_ph),
      .wrap    (h_wrap)
   );

   lcd_tgen_axis #(.CW(VW)) i_vax (
      .clk     (clk),
      .rst     (rst),
      .hold    (!running),
      .step    (h_wrap),
      .sync_m1 (v_sync_m1),
      .back_m1 (v_back_m1),
      .act_m1  (v_act_m1),
      .front_m1(v_front_m1),
      .phase   (v_ph),
      .wrap    (v_wrap)
   );

   // start on a pixel enable, stop only when the frame wraps
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         running <= 1'b0;
      end else if (!running) begin
         running <= cfg_run && pix_ce;
      end else if (v_wrap && !cfg_run) begin
         running <= 1'b0;
      end
   end

   assign hs_raw = running && (h_ph == PH_SYNC);
   assign vs_raw = running && (v_ph == PH_SYNC);
   assign de_raw = running && (h_ph == PH_ACT) && (v_ph == PH_ACT);

   assign lcd_hsync  = hs_raw ^ cfg_pol[POL_HS];
   assign lcd_vsync  = vs_raw ^ cfg_pol[POL_VS];
   assign lcd_de     = de_raw ^ cfg_pol[POL_DE];
   assign vsync_stat = vs_raw;

   lcd_tgen_irq i_irq (
      .clk    (clk),
      .rst    (rst),
      .running(running),
      .vphase (v_ph),
      .trig   (irq_trig),
      .glb_en (irq_glb_en),
      .frm_en (irq_frm_en),
      .clr    (irq_clr),
      .pend   (irq_pend)
   );
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
   parameter int unsigned DIV_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             cfg_div_sel,
   input logic [DIV_W-1:0] cfg_div_m1,
   input logic [2:0]       cfg_pol,
   input logic             irq_glb_en,
   input logic             irq_frm_en,
   input logic             pix_ce,
   input logic             lcd_hsync,
   input logic             lcd_vsync,
   input logic             lcd_de,
   input logic             vsync_stat,
   input logic             irq_pend
);
   // R4
   ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_div_sel && (cfg_div_m1 != '0) && $stable(cfg_div_m1) && $stable(cfg_div_sel) && pix_ce)
      |=> !pix_ce);

   // R2
   hs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(pix_ce) && $stable(cfg_pol)) |-> $stable(lcd_hsync));

   // R3
   de_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(pix_ce) && $stable(cfg_pol)) |-> $stable(lcd_de));

   // R3
   de_vs_chk: assert property (@(posedge clk) disable iff (rst)
      (lcd_de ^ cfg_pol[2]) |-> !vsync_stat);

   // R7
   vs_stat_chk: assert property (@(posedge clk) disable iff (rst)
      vsync_stat == (lcd_vsync ^ cfg_pol[1]));

   // R9
   pend_en_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_pend) |-> $past(irq_glb_en && irq_frm_en));
endmodule

bind lcd_tgen lcd_tgen_chk #(.DIV_W(DIV_W)) i_lcd_tgen_chk (
   .clk        (clk),
   .rst        (rst),
   .cfg_div_sel(cfg_div_sel),
   .cfg_div_m1 (cfg_div_m1),
   .cfg_pol    (cfg_pol),
   .irq_glb_en (irq_glb_en),
   .irq_frm_en (irq_frm_en),
   .pix_ce     (pix_ce),
   .lcd_hsync  (lcd_hsync),
   .lcd_vsync  (lcd_vsync),
   .lcd_de     (lcd_de),
   .vsync_stat (vsync_stat),
   .irq_pend   (irq_pend)
);

// File: tb/test_lcd_tgen.sv
`timescale 1ns/1ps
module test_lcd_tgen;
   localparam int HS = 2, HB = 3, HA = 8, HF = 2, HT = HS + HB + HA + HF;
   localparam int VS = 1, VB = 2, VA = 4, VF = 1, VT = VS + VB + VA + VF;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_run = 1'b0;
   logic       cfg_div_sel = 1'b0;
   logic [7:0] cfg_div_m1 = 8'd0;
   logic [2:0] cfg_pol = 3'b000;
   logic       irq_glb_en = 1'b0, irq_frm_en = 1'b0, irq_clr = 1'b0;
   logic [1:0] irq_trig = 2'd0;
   logic       pix_ce, lcd_hsync, lcd_vsync, lcd_de, vsync_stat, irq_pend;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lcd_tgen i_lcd_tgen (
      .clk(clk), .rst(rst), .cfg_run(cfg_run), .cfg_div_sel(cfg_div_sel),
      .cfg_div_m1(cfg_div_m1),
      .h_sync_m1(11'(HS-1)), .h_back_m1(11'(HB-1)), .h_act_m1(11'(HA-1)), .h_front_m1(11'(HF-1)),
      .v_sync_m1(11'(VS-1)), .v_back_m1(11'(VB-1)), .v_act_m1(11'(VA-1)), .v_front_m1(11'(VF-1)),
      .cfg_pol(cfg_pol), .irq_glb_en(irq_glb_en), .irq_frm_en(irq_frm_en),
      .irq_trig(irq_trig), .irq_clr(irq_clr),
      .pix_ce(pix_ce), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
      .vsync_stat(vsync_stat), .irq_pend(irq_pend)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit dsel, input logic [7:0] dm1, input logic [2:0] pol);
      @(negedge clk);
      rst = 1'b1; cfg_run = 1'b0; irq_clr = 1'b0;
      cfg_div_sel = dsel; cfg_div_m1 = dm1; cfg_pol = pol;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // run and return at the first sample of a frame (vsync_stat high)
   task automatic start_frame(output bit ok);
      cfg_run = 1'b1;
      ok = 1'b0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (vsync_stat) begin ok = 1'b1; break; end
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1; cfg_pol = 3'b000; cfg_div_sel = 1'b0;
      @(negedge clk);
      chk(lcd_hsync == 1'b0 && lcd_vsync == 1'b0 && lcd_de == 1'b0, "R1 idle outputs", {lcd_hsync, lcd_vsync, lcd_de}, 0);
      chk(vsync_stat == 1'b0 && irq_pend == 1'b0, "R1 status/pend", {vsync_stat, irq_pend}, 0);
      chk(pix_ce == 1'b1, "R1 ce bypass", pix_ce, 1);
   endtask

   task automatic t_frame(input int r, input logic [2:0] pol, input string req);
      bit ok;
      int e_hs = 0, e_vs = 0, e_de = 0, e_st = 0;
      do_reset(r > 1, 8'(r - 1), pol);
      if (pol != 3'b000)
         chk({lcd_de, lcd_vsync, lcd_hsync} == pol, "R6 idle inverted", {lcd_de, lcd_vsync, lcd_hsync}, pol);
      start_frame(ok);
      chk(ok && (lcd_hsync ^ pol[0]), "R11 hs/vs start together", lcd_hsync ^ pol[0], 1);
      for (int i = 0; i < HT * VT * r; i++) begin
         int hi, vi;
         bit ehs, evs, ede;
         hi = (i / r) % HT;
         vi = (i / r) / HT;
         ehs = hi < HS;
         evs = vi < VS;
         ede = (hi >= HS + HB) && (hi < HS + HB + HA) && (vi >= VS + VB) && (vi < VS + VB + VA);
         if (lcd_hsync !== (ehs ^ pol[0])) e_hs++;
         if (lcd_vsync !== (evs ^ pol[1])) e_vs++;
         if (lcd_de !== (ede ^ pol[2])) e_de++;
         if (vsync_stat !== evs) e_st++;
         @(negedge clk);
      end
      chk(e_hs == 0, {req, " R2 hsync sequence"}, e_hs, 0);
      chk(e_vs == 0, {req, " R3 vsync lines"}, e_vs, 0);
      chk(e_de == 0, {req, " R3 de region"}, e_de, 0);
      chk(e_st == 0, {req, " R7 vsync status"}, e_st, 0);
   endtask

   task automatic t_div;
      int n;
      do_reset(1'b1, 8'd2, 3'b000);
      n = 0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); n += int'(pix_ce); end
      chk(n == 10, "R4 ce ratio 3", n, 10);
      do_reset(1'b0, 8'd5, 3'b000);
      n = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); n += int'(pix_ce); end
      chk(n == 20, "R5 bypass ignores divider value", n, 20);
   endtask

   task automatic t_irq(input logic [1:0] trig, input int exp_n);
      bit ok;
      int n;
      do_reset(1'b0, 8'd0, 3'b000);
      irq_trig = trig; irq_glb_en = 1'b1; irq_frm_en = 1'b1;
      start_frame(ok);
      n = 0;
      while (!irq_pend && n < 300) begin @(negedge clk); n++; end
      chk(ok && n == exp_n, "R8 trigger delay", n, exp_n);
      // R10: holds without a clear, then clears on a pulse
      repeat (5) @(negedge clk);
      chk(irq_pend == 1'b1, "R10 pend held", irq_pend, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq_pend == 1'b0, "R10 write-one clear", irq_pend, 0);
      irq_glb_en = 1'b0; irq_frm_en = 1'b0;
   endtask

   task automatic t_irq_gate(input bit g, input bit f);
      bit ok;
      int n = 0;
      do_reset(1'b0, 8'd0, 3'b000);
      irq_trig = 2'd0; irq_glb_en = g; irq_frm_en = f;
      start_frame(ok);
      for (int k = 0; k < HT * VT + 30; k++) begin @(negedge clk); n += int'(irq_pend); end
      chk(ok && n == 0, "R9 both enables needed", n, 0);
      irq_glb_en = 1'b0; irq_frm_en = 1'b0;
   endtask

   task automatic t_stop;
      bit ok;
      int n = 0, h = 0;
      do_reset(1'b0, 8'd0, 3'b000);
      start_frame(ok);
      repeat (5) @(negedge clk);
      cfg_run = 1'b0;
      for (int k = 0; k < 2 * HT * VT; k++) begin @(negedge clk); n += int'(lcd_de); end
      chk(ok && n == HA * VA, "R12 frame completes", n, HA * VA);
      for (int k = 0; k < 50; k++) begin @(negedge clk); h += int'(lcd_hsync) + int'(vsync_stat); end
      chk(h == 0, "R12 idle after stop", h, 0);
   endtask

   initial begin
      t_reset();
      t_frame(1, 3'b000, "R2");
      t_frame(3, 3'b000, "R4");
      t_frame(1, 3'b111, "R6");
      t_frame(2, 3'b101, "R6");
      t_div();
      t_irq(2'd0, 1);
      t_irq(2'd1, VS * HT + 1);
      t_irq(2'd2, (VS + VB) * HT + 1);
      t_irq(2'd3, (VS + VB + VA) * HT + 1);
      t_irq_gate(1'b1, 1'b0);
      t_irq_gate(1'b0, 1'b1);
      t_stop();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule